// File: doc/BRIEF.md
# Single-Bus Multicycle Datapath

This block is the data half of a multicycle 32-bit processor in which every transfer between storage elements travels over one shared bus. An outside microcode sequencer supplies a fresh control word each cycle. That word decides which of four sources (immediate extender, ALU, register file, memory read port) drives the bus and which storage elements capture it: the instruction register, the operand latches A and B, the memory address register, and a register file of 32 general registers plus the program counter.

The block sends the sequencer the opcode field of the held instruction and a flag that says whether operand A is zero, so the sequencer can dispatch and branch. Memory sits outside the block. It sees the address register, the bus as write data and a write strobe. Memory answers slowly, and while it reports busy, a transfer that takes its data from memory is held off.

Top module: `sbus_datapath`

## Requirements
- R1: While reset (`rst_n` low) is asserted, every register file entry, IR, A, B and MA clear to zero. After reset, `opcode` is 0, `zero` is 1 and `mem_addr` is 0.
- R2: The bus carries the value of the single enabled source. With no enable it reads zero. Having more than one of `en_imm`, `en_alu`, `en_reg`, `en_mem` asserted in a cycle is a protocol error and is flagged.
- R3: `reg_sel` picks the register index as follows: 0 takes IR[25:21], 1 takes IR[20:16], 2 takes IR[15:11], 3 is the link slot (index 31), 4 is the program counter slot (index 32), and 5 to 7 select index 0. With `en_reg`, the bus carries the selected entry.
- R4: Index 0 always reads as zero. A write to index 0 has no effect.
- R5: With `reg_wr`, the bus value is written at the clock edge into the entry that `reg_sel` selects.
- R6: `ld_ir`, `ld_a`, `ld_b` and `ld_ma` each capture the bus at the clock edge. `opcode` shows IR[31:26] and `mem_addr` shows MA.
- R7: With `en_imm`, the bus carries the immediate as set by `ext_sel`: 0 sign-extends IR[15:0], 1 zero-extends IR[15:0], 2 sign-extends IR[25:0], and 3 gives zero.
- R8: With `en_alu`, the bus carries the result of A and B under `alu_op`: 0 A+B, 1 A−B, 2 A&B, 3 A|B, 4 A^B, 5 signed A<B as 1 or 0, 6 A+4, 7 A shifted left by B[4:0].
- R9: `zero` is 1 exactly when the A latch holds zero.
- R10: In a cycle with both `en_mem` and `mem_busy` high, no latch and no register file entry changes.
- R11: `mem_wdata` always carries the bus value, and `mem_we` follows `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_ir | input | 1 | Capture bus into IR |
| ld_a | input | 1 | Capture bus into A |
| ld_b | input | 1 | Capture bus into B |
| ld_ma | input | 1 | Capture bus into MA |
| reg_wr | input | 1 | Write bus into selected register |
| mem_wr | input | 1 | Memory write request |
| en_imm | input | 1 | Extender drives bus |
| en_alu | input | 1 | ALU drives bus |
| en_reg | input | 1 | Register file drives bus |
| en_mem | input | 1 | Memory read data drives bus |
| reg_sel | input | 3 | Register index select |
| ext_sel | input | 2 | Extension mode |
| alu_op | input | 3 | ALU function |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory not yet done |
| opcode | output | 6 | IR[31:26] |
| zero | output | 1 | A equals zero |
| mem_addr | output | 32 | Memory address (MA) |
| mem_wdata | output | 32 | Memory write data (bus) |
| mem_we | output | 1 | Memory write strobe |

## Verification
The bench goes after register index 0 when it is reached through an instruction field. A design that let a write land there would return a nonzero value on the next read. It checks the fixed link and counter slots, where an off-by-one decode would corrupt a general register. It drives the upper immediate bits set in all three extension modes, where an extender that fills from the wrong bit would change the top of the word. It also runs memory-sourced loads while busy is held, where a design that ignored busy would latch stale data into IR or MA and change `opcode` or `mem_addr` early. Random control words with one driver or none, mixed with random memory data and random busy, check every bus value and every visible register against a reference model after each edge.

// File: rtl/sbus_pkg.sv
// Shared encodings for the single-bus datapath.
// Assumes: the control word fields use these codes. Widths are fixed by the instruction layout.
package sbus_pkg;
    // register index select codes
    localparam logic [2:0] RSEL_F1   = 3'd0;
    localparam logic [2:0] RSEL_F2   = 3'd1;
    localparam logic [2:0] RSEL_F3   = 3'd2;
    localparam logic [2:0] RSEL_LINK = 3'd3;
    localparam logic [2:0] RSEL_PC   = 3'd4;

    // immediate extension modes
    localparam logic [1:0] EXT_S16 = 2'd0;
    localparam logic [1:0] EXT_Z16 = 2'd1;
    localparam logic [1:0] EXT_S26 = 2'd2;

    // ALU functions
    localparam logic [2:0] ALU_ADD  = 3'd0;
    localparam logic [2:0] ALU_SUB  = 3'd1;
    localparam logic [2:0] ALU_AND  = 3'd2;
    localparam logic [2:0] ALU_OR   = 3'd3;
    localparam logic [2:0] ALU_XOR  = 3'd4;
    localparam logic [2:0] ALU_SLT  = 3'd5;
    localparam logic [2:0] ALU_INC4 = 3'd6;
    localparam logic [2:0] ALU_SHL  = 3'd7;

    // bus source slots, lowest slot wins if several are enabled
    localparam int DRV_IMM = 0;
    localparam int DRV_ALU = 1;
    localparam int DRV_REG = 2;
    localparam int DRV_MEM = 3;
    localparam int NUM_DRV = 4;
endpackage

// File: rtl/sbus_regfile.sv
// Register file of NREG general entries plus a program counter slot.
// Decodes the index from three instruction fields or from the fixed slots.
// Assumes: entry 0 is hardwired to zero, the link slot is NREG-1, the PC slot is NREG.
module sbus_regfile
    import sbus_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 32,
    parameter int FW    = 5,
    parameter int IDX_W = $clog2(NREG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sel,
    input  logic [FW-1:0] fld1,
    input  logic [FW-1:0] fld2,
    input  logic [FW-1:0] fld3,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int LINK_IDX = NREG - 1;
    localparam int PC_IDX   = NREG;

    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    ent_q [1:NREG];

    // index decode from select code
    always_comb begin
        case (sel)
            RSEL_F1:   idx = IDX_W'(fld1);
            RSEL_F2:   idx = IDX_W'(fld2);
            RSEL_F3:   idx = IDX_W'(fld3);
            RSEL_LINK: idx = IDX_W'(LINK_IDX);
            RSEL_PC:   idx = IDX_W'(PC_IDX);
            default:   idx = '0;
        endcase
    end

    // one storage entry per index, index 0 has none
    for (genvar g = 1; g <= NREG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (we && idx == IDX_W'(g))
                ent_q[g] <= wdata;
        end
    end

    // read port, index 0 yields zero
    always_comb begin
        rdata = '0;
        for (int i = 1; i <= NREG; i++)
            if (idx == IDX_W'(i))
                rdata = ent_q[i];
    end
endmodule

// File: rtl/sbus_extend.sv
// Immediate extender: widens a 16-bit or 26-bit field from the instruction.
// Assumes: DW is at least 26.
module sbus_extend
    import sbus_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [25:0]   imm,
    input  logic [1:0]    mode,
    output logic [DW-1:0] value
);
    // mode select
    always_comb begin
        case (mode)
            EXT_S16: value = {{(DW-16){imm[15]}}, imm[15:0]};
            EXT_Z16: value = {{(DW-16){1'b0}}, imm[15:0]};
            EXT_S26: value = {{(DW-26){imm[25]}}, imm};
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/sbus_alu.sv
// Combinational ALU over the A and B latches.
// Assumes: DW is a power of two, so that the shift amount is the low log2(DW) bits of B.
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [2:0]    op,
    output logic [DW-1:0] y
);
    localparam int SH_W = $clog2(DW);

    // function select
    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SLT:  y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_INC4: y = a + DW'(4);
            default:  y = a << b[SH_W-1:0];
        endcase
    end
endmodule

// File: rtl/sbus_busmux.sv
// Bus arbiter: passes the enabled source. The lowest-numbered enable wins. The bus is zero when none is enabled.
// Assumes: the sequencer enables at most one source (a checker flags more).
module sbus_busmux #(
    parameter int DW = 32,
    parameter int N  = 4
) (
    input  logic [N-1:0]         en,
    input  logic [N-1:0][DW-1:0] src,
    output logic [DW-1:0]        bus
);
    logic [N-1:0]         grant;
    logic [N-1:0][DW-1:0] gated;

    for (genvar g = 0; g < N; g++) begin : g_slot
        if (g == 0) begin : g_first
            assign grant[g] = en[g];
        end else begin : g_rest
            assign grant[g] = en[g] & ~|en[g-1:0];
        end
        assign gated[g] = grant[g] ? src[g] : '0;
    end

    // OR-combine the gated sources
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++)
            bus = bus | gated[i];
    end
endmodule

// File: rtl/sbus_datapath.sv
// Single-bus multicycle datapath: IR, A, B, MA latches, register file with PC slot,
// extender, ALU and memory port, all joined by one arbitrated bus.
// Assumes: a sequencer outside the block supplies one control word per cycle. A transfer
// sourced from memory while memory is busy is suppressed.
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_ir,
    input  logic          ld_a,
    input  logic          ld_b,
    input  logic          ld_ma,
    input  logic          reg_wr,
    input  logic          mem_wr,
    input  logic          en_imm,
    input  logic          en_alu,
    input  logic          en_reg,
    input  logic          en_mem,
    input  logic [2:0]    reg_sel,
    input  logic [1:0]    ext_sel,
    input  logic [2:0]    alu_op,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_busy,
    output logic [5:0]    opcode,
    output logic          zero,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we
);
    logic [DW-1:0] ir_q, a_q, b_q, ma_q;
    logic [DW-1:0] bus_w, imm_w, alu_w, rf_w;
    logic [NUM_DRV-1:0]         drv_en;
    logic [NUM_DRV-1:0][DW-1:0] drv_val;
    logic hold;

    assign hold = en_mem & mem_busy;

    // gather bus sources in priority slots
    always_comb begin
        drv_en           = '0;
        drv_en[DRV_IMM]  = en_imm;
        drv_en[DRV_ALU]  = en_alu;
        drv_en[DRV_REG]  = en_reg;
        drv_en[DRV_MEM]  = en_mem;
        drv_val          = '0;
        drv_val[DRV_IMM] = imm_w;
        drv_val[DRV_ALU] = alu_w;
        drv_val[DRV_REG] = rf_w;
        drv_val[DRV_MEM] = mem_rdata;
    end

    sbus_busmux #(.DW(DW), .N(NUM_DRV)) i_mux (
        .en  (drv_en),
        .src (drv_val),
        .bus (bus_w)
    );

    sbus_extend #(.DW(DW)) i_ext (
        .imm   (ir_q[25:0]),
        .mode  (ext_sel),
        .value (imm_w)
    );

    sbus_alu #(.DW(DW)) i_alu (
        .a  (a_q),
        .b  (b_q),
        .op (alu_op),
        .y  (alu_w)
    );

    sbus_regfile #(.DW(DW), .NREG(NREG), .FW(5)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (reg_sel),
        .fld1  (ir_q[25:21]),
        .fld2  (ir_q[20:16]),
        .fld3  (ir_q[15:11]),
        .we    (reg_wr & ~hold),
        .wdata (bus_w),
        .rdata (rf_w)
    );

    // latch capture from bus, frozen while memory data is not ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            ma_q <= '0;
        end else if (!hold) begin
            if (ld_ir) ir_q <= bus_w;
            if (ld_a)  a_q  <= bus_w;
            if (ld_b)  b_q  <= bus_w;
            if (ld_ma) ma_q <= bus_w;
        end
    end

    assign opcode    = ir_q[31:26];
    assign zero      = (a_q == '0);
    assign mem_addr  = ma_q;
    assign mem_wdata = bus_w;
    assign mem_we    = mem_wr;
endmodule

// File: rtl/sbus_datapath_chk.sv
// Protocol and transfer checks for sbus_datapath, attached by bind.
// Assumes: it sees the internal bus of the datapath through the bind connection.
module sbus_datapath_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_imm,
    input logic          en_alu,
    input logic          en_reg,
    input logic          en_mem,
    input logic          mem_busy,
    input logic          ld_ir,
    input logic          ld_a,
    input logic          ld_ma,
    input logic [DW-1:0] bus,
    input logic [5:0]    opcode,
    input logic          zero,
    input logic [DW-1:0] mem_addr
);
    logic held;
    assign held = en_mem & mem_busy;

    p_single_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({en_imm, en_alu, en_reg, en_mem}) <= 1);

    p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_imm | en_alu | en_reg | en_mem) |-> bus == '0);

    p_ir_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ir && !held) |=> opcode == $past(bus[DW-1:DW-6]));

    p_ma_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ma && !held) |=> mem_addr == $past(bus));

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a && !held) |=> zero == ($past(bus) == '0));

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(opcode) && $stable(mem_addr) && $stable(zero)));
endmodule

bind sbus_datapath sbus_datapath_chk #(.DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_imm   (en_imm),
    .en_alu   (en_alu),
    .en_reg   (en_reg),
    .en_mem   (en_mem),
    .mem_busy (mem_busy),
    .ld_ir    (ld_ir),
    .ld_a     (ld_a),
    .ld_ma    (ld_ma),
    .bus      (bus_w),
    .opcode   (opcode),
    .zero     (zero),
    .mem_addr (mem_addr)
);

// File: tb/test_sbus_datapath.sv
module test_sbus_datapath;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic ld_ir, ld_a, ld_b, ld_ma, reg_wr, mem_wr;
    logic en_imm, en_alu, en_reg, en_mem, mem_busy;
    logic [2:0] reg_sel, alu_op;
    logic [1:0] ext_sel;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic [5:0] opcode;
    logic zero, mem_we;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [31:0] m_rf [0:32];
    logic [31:0] m_ir, m_a, m_b, m_ma;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbus_datapath i_sbus_datapath (
        .clk(clk), .rst_n(rst_n), .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
        .reg_wr(reg_wr), .mem_wr(mem_wr), .en_imm(en_imm), .en_alu(en_alu), .en_reg(en_reg),
        .en_mem(en_mem), .reg_sel(reg_sel), .ext_sel(ext_sel), .alu_op(alu_op),
        .mem_rdata(mem_rdata), .mem_busy(mem_busy), .opcode(opcode), .zero(zero),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [2:0] s, input logic [31:0] ir);
        case (s)
            3'd0: return int'(ir[25:21]);
            3'd1: return int'(ir[20:16]);
            3'd2: return int'(ir[15:11]);
            3'd3: return 31;
            3'd4: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] ext_of(input logic [1:0] m, input logic [31:0] ir);
        case (m)
            2'd0: return {{16{ir[15]}}, ir[15:0]};
            2'd1: return {16'h0, ir[15:0]};
            2'd2: return {{6{ir[25]}}, ir[25:0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] alu_of(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd6: return a + 32'd4;
            default: return a << b[4:0];
        endcase
    endfunction

    function automatic logic [31:0] exp_bus();
        if (en_imm) return ext_of(ext_sel, m_ir);
        if (en_alu) return alu_of(alu_op, m_a, m_b);
        if (en_reg) return m_rf[idx_of(reg_sel, m_ir)];
        if (en_mem) return mem_rdata;
        return 32'h0;
    endfunction

    task automatic clear();
        {ld_ir, ld_a, ld_b, ld_ma, reg_wr, mem_wr} = '0;
        {en_imm, en_alu, en_reg, en_mem, mem_busy} = '0;
        reg_sel = 0; ext_sel = 0; alu_op = 0; mem_rdata = 0;
    endtask

    // one cycle: inputs already driven after a falling edge; ends at the next falling edge
    task automatic step(input string bus_req, input string post_req);
        logic [31:0] eb;
        int widx;
        bit hold;
        #1;
        eb = exp_bus();
        chk(mem_wdata === eb, bus_req, mem_wdata, eb);
        chk(mem_we === mem_wr, "R11", {31'b0, mem_we}, {31'b0, mem_wr});
        widx = idx_of(reg_sel, m_ir);
        hold = en_mem && mem_busy;
        @(posedge clk);
        if (!hold) begin
            if (reg_wr && widx != 0) m_rf[widx] = eb;
            if (ld_ir) m_ir = eb;
            if (ld_a)  m_a = eb;
            if (ld_b)  m_b = eb;
            if (ld_ma) m_ma = eb;
        end
        #1;
        chk(opcode === m_ir[31:26], post_req, {26'b0, opcode}, {26'b0, m_ir[31:26]});
        chk(mem_addr === m_ma, post_req, mem_addr, m_ma);
        chk(zero === (m_a == 0), "R9", {31'b0, zero}, {31'b0, (m_a == 0)});
        @(negedge clk);
    endtask

    task automatic mem_load(input logic [31:0] d, input bit ir, input bit a, input bit b, input bit ma);
        clear(); en_mem = 1; mem_rdata = d;
        ld_ir = ir; ld_a = a; ld_b = b; ld_ma = ma;
        step("R2", "R6");
    endtask

    task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
        clear(); en_mem = 1; mem_rdata = d; reg_sel = s; reg_wr = 1;
        step("R5", "R6");
    endtask

    task automatic reg_read(input logic [2:0] s, input string req);
        clear(); en_reg = 1; reg_sel = s;
        step(req, "R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd7531);
        clear();
        for (int i = 0; i <= 32; i++) m_rf[i] = 0;
        m_ir = 0; m_a = 0; m_b = 0; m_ma = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(opcode === 6'd0, "R1", {26'b0, opcode}, 32'h0);
        chk(zero === 1'b1, "R1", {31'b0, zero}, 32'h1);
        chk(mem_addr === 32'h0, "R1", mem_addr, 32'h0);
        chk(mem_wdata === 32'h0, "R2", mem_wdata, 32'h0);
        @(negedge clk);
        reg_read(3'd4, "R1");

        // R10 IR load while busy is held off, then completes
        clear(); en_mem = 1; mem_busy = 1; ld_ir = 1; ld_ma = 1; ld_a = 1;
        mem_rdata = {6'h2B, 5'd0, 5'd7, 5'd31, 11'h001};
        step("R2", "R10");
        chk(opcode === 6'd0, "R10", {26'b0, opcode}, 32'h0);
        chk(mem_addr === 32'h0, "R10", mem_addr, 32'h0);
        clear(); en_mem = 1; mem_busy = 1; reg_wr = 1; reg_sel = 3'd4; mem_rdata = 32'hDEAD_0001;
        step("R2", "R10");
        reg_read(3'd4, "R10");
        mem_load({6'h2B, 5'd0, 5'd7, 5'd31, 11'h001}, 1, 0, 0, 1);
        chk(opcode === 6'h2B, "R6", {26'b0, opcode}, 32'h2B);

        // R4 field rf1 is 0: write ignored, reads zero
        reg_write(3'd0, 32'hFFFF_FFFF);
        reg_read(3'd0, "R4");
        reg_write(3'd5, 32'h1234_5678);
        reg_read(3'd6, "R4");
        // R5 / R3 write through rf2 (index 7), rf3 (index 31 equals link slot)
        reg_write(3'd1, 32'hA5A5_0007);
        reg_read(3'd1, "R3");
        reg_write(3'd3, 32'h0000_0031);
        reg_read(3'd2, "R3");
        reg_write(3'd4, 32'h0000_1000);
        reg_read(3'd4, "R3");
        reg_read(3'd3, "R5");

        // R7 extension with high bits set
        mem_load({6'h02, 26'h2_0000 | 26'h8001 | 26'h200_0000}, 1, 0, 0, 0);
        for (int m = 0; m < 4; m++) begin
            clear(); en_imm = 1; ext_sel = 2'(m);
            step("R7", "R6");
        end

        // R8 A+4 and other functions, R9 zero flag
        mem_load(32'h0000_0000, 0, 1, 0, 0);
        chk(zero === 1'b1, "R9", {31'b0, zero}, 32'h1);
        mem_load(32'hFFFF_FFFC, 0, 1, 0, 0);
        mem_load(32'h0000_0003, 0, 0, 1, 0);
        for (int o = 0; o < 8; o++) begin
            clear(); en_alu = 1; alu_op = 3'(o);
            step("R8", "R6");
        end
        clear(); en_alu = 1; alu_op = 3'd6; ld_a = 1;
        step("R8", "R9");
        chk(zero === 1'b1, "R9", {31'b0, zero}, 32'h1);

        // random control words, one source or none
        for (int n = 0; n < 1500; n++) begin
            int pick;
            string tag;
            clear();
            pick = int'($urandom_range(0, 4));
            case (pick)
                0: begin en_imm = 1; tag = "R7"; end
                1: begin en_alu = 1; tag = "R8"; end
                2: begin en_reg = 1; tag = "R3"; end
                3: begin en_mem = 1; tag = "R2"; end
                default: tag = "R2";
            endcase
            mem_busy = ($urandom_range(0, 3) == 0);
            mem_rdata = (($urandom_range(0, 7) == 0) ? 32'h0 : $urandom());
            ld_ir = ($urandom_range(0, 5) == 0);
            ld_a  = ($urandom_range(0, 2) == 0);
            ld_b  = ($urandom_range(0, 2) == 0);
            ld_ma = ($urandom_range(0, 2) == 0);
            reg_wr = ($urandom_range(0, 2) == 0);
            mem_wr = ($urandom_range(0, 3) == 0);
            reg_sel = 3'($urandom_range(0, 7));
            ext_sel = 2'($urandom_range(0, 3));
            alu_op = 3'($urandom_range(0, 7));
            step(tag, (en_mem && mem_busy) ? "R10" : "R6");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule